// File: doc/BRIEF.md
# UART Transmit Engine

This block is the transmit half of an asynchronous serial port. A single write loads a character into a one-entry holding register. When the line is free, the character moves into a shift register and goes out on the TX line. The frame is a low start bit, then the data bits least significant first, then an optional parity bit, then one high stop bit. The character may be 7, 8 or 9 bits wide. The parity bit can be odd, even, or held at a fixed 0 or 1. In 9-bit mode no parity bit is sent.

Bit timing comes from an external one-cycle `baud_tick` enable, and every frame bit lasts exactly one tick interval. A character written while a frame is on the line waits in the holding register. It starts on the tick that ends the current stop bit, so there is no idle gap between the two frames. A level-held break input forces the line low while the frame timing keeps running.

The state machine has five states:
- `ST_IDLE`: the line is high.
- `ST_START`: the start bit is on the line.
- `ST_DATA`: the data bits are on the line.
- `ST_PARITY`: the parity bit is on the line.
- `ST_STOP`: the stop bit is on the line.

All transitions happen only on a tick:
- T_LOAD: `ST_IDLE` goes to `ST_START` when the holding register is full.
- T_BITS: `ST_START` goes to `ST_DATA`.
- T_DATA_END: `ST_DATA` goes to `ST_PARITY`, or to `ST_STOP` when there is no parity bit, after the last data bit.
- T_PAR: `ST_PARITY` goes to `ST_STOP`.
- T_CHAIN: `ST_STOP` goes to `ST_START` when the holding register is full.
- T_DONE: `ST_STOP` goes to `ST_IDLE` otherwise.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset `tx` is 1, `buf_empty` is 1 and `tx_busy` is 0.
- R2: When idle with no break, `tx` is 1. A frame is start (0), data LSB first, optional parity, stop (1), and each bit lasts one `baud_tick` interval.
- R3: `len_code` selects the data width: 00 gives 7 bits, 01 gives 8 bits, 10 gives 9 bits, and 11 gives 8 bits.
- R4: With `par_en`=1 and a width other than 9, a parity bit follows the data. `par_sel` sets its value:
  - 00: odd, so the count of ones in the data and parity bit is odd.
  - 01: even.
  - 10: always 0.
  - 11: always 1.
  With `par_en`=0 there is no parity slot.
- R5: In 9-bit mode no parity bit is sent, whatever `par_en` and `par_sel` are.
- R6: While `brk` is 1, `tx` is 0. The frame timing continues underneath, and the line returns to normal when `brk` clears.
- R7: `buf_empty` reads 0 in the cycle after a write. It returns to 1 on the clock edge where the held character moves into the shift register, which is the same edge where `tx_busy` rises.
- R8: With the engine idle, transmission starts on the first `baud_tick` after the holding register fills. `tx_busy` is 1 from the start bit through the stop bit and 0 once the stop bit ends with nothing held.
- R9: A character written during a frame starts on the tick that ends that frame's stop bit. There is no idle bit between the frames and `tx_busy` stays 1.
- R10: Width and parity settings are captured when a character is loaded into the shift register. Changing them mid-frame does not alter that frame.
- R11: A write while the holding register is already full replaces the held character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle bit-rate enable |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_MAX | Character to send, LSB first |
| len_code | input | 2 | Data width select |
| par_en | input | 1 | Parity enable |
| par_sel | input | 2 | Parity kind select |
| brk | input | 1 | Force line low (break) |
| tx | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding register is empty |
| tx_busy | output | 1 | A frame is being shifted out |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse separated by at least one idle cycle. They also assume that `wr_en` is a single-cycle strobe and that `brk` is synchronous to `clk`. The bench derives the tick from a free-running counter that pulses once every four clocks. It drives every input at falling edges, so each input changes only between active edges. Random characters, widths and parity settings are mixed with directed cases for chaining, overwrite, mid-frame setting changes and break.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_e;

    localparam logic [1:0] LEN_7  = 2'b00;
    localparam logic [1:0] LEN_8  = 2'b01;
    localparam logic [1:0] LEN_9  = 2'b10;
    localparam logic [1:0] LEN_8B = 2'b11;

    localparam logic [1:0] PAR_ODD  = 2'b00;
    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ZERO = 2'b10;
    localparam logic [1:0] PAR_ONE  = 2'b11;

    // Number of data bits for a width code.
    function automatic int data_bits(input logic [1:0] code);
        unique case (code)
            LEN_7:   return 7;
            LEN_9:   return 9;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_holdreg.sv
module uart_tx_holdreg #(
    parameter int DATA_MAX = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic                take,
    output logic                full,
    output logic [DATA_MAX-1:0] data
);

    logic                full_q;
    logic [DATA_MAX-1:0] data_q;

    // A write wins over a same-cycle transfer and replaces held data (R11).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (wr_en) begin
            full_q <= 1'b1;
            data_q <= wr_data;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    assign full = full_q;
    assign data = data_q;

    // R7: a transfer only happens from a full holding register
    a_r7_take_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full_q);

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
    import uart_tx_pkg::*;
#(
    parameter int DATA_MAX = 9
) (
    input  logic [DATA_MAX-1:0] data,
    input  logic [1:0]          len_code,
    input  logic                par_en,
    input  logic [1:0]          par_sel,
    output logic                par_on,
    output logic                par_bit
);

    logic [DATA_MAX-1:0] mask;
    logic                ones_odd;

    for (genvar gi = 0; gi < DATA_MAX; gi++) begin : g_mask
        assign mask[gi] = (gi < data_bits(len_code));
    end

    assign ones_odd = ^(data & mask);

    // R5: no parity slot in 9-bit mode
    assign par_on = par_en && (len_code != LEN_9);

    always_comb begin
        unique case (par_sel)
            PAR_ODD:  par_bit = ~ones_odd;
            PAR_EVEN: par_bit = ones_odd;
            PAR_ZERO: par_bit = 1'b0;
            default:  par_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int DATA_MAX = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                baud_tick,
    input  logic                hold_full,
    input  logic [DATA_MAX-1:0] hold_data,
    input  logic [1:0]          len_code,
    input  logic                par_on,
    input  logic                par_bit,
    input  logic                brk,
    output logic                take,
    output logic                tx,
    output logic                busy
);

    localparam int CNT_W = $clog2(DATA_MAX + 1);

    tx_state_e           state_q, state_d;
    logic [DATA_MAX-1:0] shreg_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    nbits_q;
    logic                par_on_q;
    logic                par_bit_q;
    logic                last_data;

    assign last_data = (cnt_q == nbits_q - CNT_W'(1));

    // Next state; every transition waits for a tick.
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        if (baud_tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (hold_full) begin            // T_LOAD
                        take    = 1'b1;
                        state_d = ST_START;
                    end
                end
                ST_START:  state_d = ST_DATA;       // T_BITS
                ST_DATA: begin
                    if (last_data)                  // T_DATA_END
                        state_d = par_on_q ? ST_PARITY : ST_STOP;
                end
                ST_PARITY: state_d = ST_STOP;       // T_PAR
                ST_STOP: begin
                    if (hold_full) begin            // T_CHAIN
                        take    = 1'b1;
                        state_d = ST_START;
                    end else begin                  // T_DONE
                        state_d = ST_IDLE;
                    end
                end
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Shift datapath; frame settings captured at load (R10)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            cnt_q     <= '0;
            nbits_q   <= CNT_W'(8);
            par_on_q  <= 1'b0;
            par_bit_q <= 1'b0;
        end else if (take) begin
            shreg_q   <= hold_data;
            cnt_q     <= '0;
            nbits_q   <= CNT_W'(data_bits(len_code));
            par_on_q  <= par_on;
            par_bit_q <= par_bit;
        end else if (baud_tick && state_q == ST_DATA) begin
            shreg_q <= shreg_q >> 1;
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
        unique case (state_q)
            ST_START:  tx = 1'b0;
            ST_DATA:   tx = shreg_q[0];
            ST_PARITY: tx = par_bit_q;
            default:   tx = 1'b1;
        endcase
        if (brk) tx = 1'b0;                         // R6
    end

    // R2: the state only moves on a tick
    a_r2_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(state_q));

    // R8: a frame begins only on a tick
    a_r8_start_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(baud_tick));

    // R3: the data bit counter never passes the captured width
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DATA |-> cnt_q < nbits_q);

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine #(
    parameter int DATA_MAX = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                baud_tick,
    input  logic                wr_en,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic [1:0]          len_code,
    input  logic                par_en,
    input  logic [1:0]          par_sel,
    input  logic                brk,
    output logic                tx,
    output logic                buf_empty,
    output logic                tx_busy
);

    logic                hold_full;
    logic [DATA_MAX-1:0] hold_data;
    logic                take;
    logic                par_on;
    logic                par_bit;

    uart_tx_holdreg #(.DATA_MAX(DATA_MAX)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_tx_parity #(.DATA_MAX(DATA_MAX)) u_par (
        .data     (hold_data),
        .len_code (len_code),
        .par_en   (par_en),
        .par_sel  (par_sel),
        .par_on   (par_on),
        .par_bit  (par_bit)
    );

    uart_tx_fsm #(.DATA_MAX(DATA_MAX)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .len_code  (len_code),
        .par_on    (par_on),
        .par_bit   (par_bit),
        .brk       (brk),
        .take      (take),
        .tx        (tx),
        .busy      (tx_busy)
    );

    assign buf_empty = !hold_full;

    a_r6_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !tx);

    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy && !brk |-> tx);

    a_r7_empty_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !buf_empty);

    a_r8_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) && !brk |-> !tx);

endmodule

// File: tb/uart_tx_engine_tb.sv
`timescale 1ns/1ps
module uart_tx_engine_tb;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic [1:0] len_code = 2'b01;
    logic       par_en = 1'b0;
    logic [1:0] par_sel = 2'b00;
    logic       brk = 1'b0;
    logic       tx, buf_empty, tx_busy;
    logic [1:0] tcnt = '0;
    logic       baud_tick;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) tcnt <= tcnt + 2'd1;
    assign baud_tick = (tcnt == 2'(DIV - 1));

    uart_tx_engine u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .len_code(len_code), .par_en(par_en),
        .par_sel(par_sel), .brk(brk), .tx(tx), .buf_empty(buf_empty),
        .tx_busy(tx_busy)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic void build_frame(input logic [8:0] d, input logic [1:0] len,
                                        input logic pe, input logic [1:0] ps,
                                        output logic [11:0] bits, output int n);
        int  nb;
        logic ones;
        nb = (len == 2'b00) ? 7 : (len == 2'b10) ? 9 : 8;
        bits = '0;
        ones = 1'b0;
        bits[0] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            bits[1+i] = d[i];
            ones ^= d[i];
        end
        n = 1 + nb;
        if (pe && nb != 9) begin
            case (ps)
                2'b00: bits[n] = ~ones;
                2'b01: bits[n] = ones;
                2'b10: bits[n] = 1'b0;
                default: bits[n] = 1'b1;
            endcase
            n++;
        end
        bits[n] = 1'b1;
        n++;
    endfunction

    task automatic do_write(input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_start();
        while (!tx_busy) @(negedge clk);
    endtask

    // Samples n bits, one per tick interval, starting at a bit boundary.
    task automatic collect(input int n, input logic w1, input logic [8:0] d1,
                           input logic w2, input logic [8:0] d2,
                           input logic scramble, output logic [11:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            got[i] = tx;
            if (i == n - 1) check("R8 busy during stop", 32'(tx_busy), 32'd1);
            if (i == 1 && w1) begin wr_en = 1'b1; wr_data = d1; end
            if (i == 2 && w2) begin wr_en = 1'b1; wr_data = d2; end
            if (i == 2 && scramble) begin
                len_code = 2'($urandom_range(0, 3));
                par_en = ~par_en;
                par_sel = 2'($urandom_range(0, 3));
            end
            for (int k = 0; k < DIV; k++) begin
                @(negedge clk);
                if (k == 0) wr_en = 1'b0;
            end
        end
    endtask

    task automatic send_check(input string req, input logic [8:0] d, input logic [1:0] len,
                              input logic pe, input logic [1:0] ps, input logic scramble);
        logic [11:0] exp, got;
        int n;
        len_code = len; par_en = pe; par_sel = ps;
        build_frame(d, len, pe, ps, exp, n);
        do_write(d);
        check("R7 empty clears after write", 32'(buf_empty), 32'd0);
        wait_start();
        check("R7 empty set at load", 32'(buf_empty), 32'd1);
        collect(n, 1'b0, '0, 1'b0, '0, scramble, got);
        check(req, 32'(got), 32'(exp));
        check("R8 busy low after stop", 32'(tx_busy), 32'd0);
        check("R2 idle high", 32'(tx), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired got=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [11:0] ea, eb, got;
        int na, nb;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1
        check("R1 reset tx", 32'(tx), 32'd1);
        check("R1 reset empty", 32'(buf_empty), 32'd1);
        check("R1 reset busy", 32'(tx_busy), 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 after release", {tx, buf_empty, tx_busy}, 32'b110);

        // R2/R3 widths
        send_check("R3 width 7", 9'h055, 2'b00, 1'b0, 2'b00, 1'b0);
        send_check("R2 width 8", 9'h0A3, 2'b01, 1'b0, 2'b00, 1'b0);
        send_check("R3 width 9", 9'h1C4, 2'b10, 1'b0, 2'b00, 1'b0);
        send_check("R3 code 11 is 8", 9'h1F0, 2'b11, 1'b0, 2'b00, 1'b0);
        // R4 parity codes
        send_check("R4 odd", 9'h003, 2'b01, 1'b1, 2'b00, 1'b0);
        send_check("R4 even", 9'h007, 2'b01, 1'b1, 2'b01, 1'b0);
        send_check("R4 fixed 0", 9'h0FF, 2'b01, 1'b1, 2'b10, 1'b0);
        send_check("R4 fixed 1", 9'h000, 2'b00, 1'b1, 2'b11, 1'b0);
        // R5
        send_check("R5 no parity 9-bit", 9'h101, 2'b10, 1'b1, 2'b11, 1'b0);
        // R10
        send_check("R10 settings captured", 9'h05A, 2'b01, 1'b1, 2'b00, 1'b1);
        send_check("R10 settings captured 2", 9'h133, 2'b10, 1'b0, 2'b01, 1'b1);

        // R9 back-to-back
        len_code = 2'b01; par_en = 1'b1; par_sel = 2'b01;
        build_frame(9'h0C3, 2'b01, 1'b1, 2'b01, ea, na);
        build_frame(9'h03C, 2'b01, 1'b1, 2'b01, eb, nb);
        do_write(9'h0C3);
        wait_start();
        collect(na, 1'b1, 9'h03C, 1'b0, '0, 1'b0, got);
        check("R9 first frame", 32'(got), 32'(ea));
        check("R9 busy held at chain", 32'(tx_busy), 32'd1);
        check("R9 no idle gap", 32'(tx), 32'd0);
        collect(nb, 1'b0, '0, 1'b0, '0, 1'b0, got);
        check("R9 second frame", 32'(got), 32'(eb));
        check("R9 busy low at end", 32'(tx_busy), 32'd0);

        // R11 overwrite while full
        len_code = 2'b00; par_en = 1'b0;
        build_frame(9'h011, 2'b00, 1'b0, 2'b00, ea, na);
        build_frame(9'h06E, 2'b00, 1'b0, 2'b00, eb, nb);
        do_write(9'h011);
        wait_start();
        collect(na, 1'b1, 9'h022, 1'b1, 9'h06E, 1'b0, got);
        check("R11 first frame", 32'(got), 32'(ea));
        collect(nb, 1'b0, '0, 1'b0, '0, 1'b0, got);
        check("R11 replaced character", 32'(got), 32'(eb));

        // R6 break while idle
        brk = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R6 break idle low", 32'(tx), 32'd0);
        end
        brk = 1'b0;
        @(negedge clk);
        check("R6 line back high", 32'(tx), 32'd1);
        // R6 break during frame
        len_code = 2'b01;
        do_write(9'h0FF);
        wait_start();
        brk = 1'b1;
        for (int i = 0; i < 6 * DIV; i++) begin
            @(negedge clk);
            check("R6 break in frame low", 32'(tx), 32'd0);
        end
        check("R6 frame continues", 32'(tx_busy), 32'd1);
        brk = 1'b0;
        @(negedge clk);
        check("R6 data resumes", 32'(tx), 32'd1);
        while (tx_busy) @(negedge clk);
        repeat (2 * DIV) @(negedge clk);

        // Random frames
        for (int r = 0; r < 40; r++) begin
            send_check("R2 random frame", 9'($urandom_range(0, 511)),
                       2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                       2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
            repeat ($urandom_range(0, 5)) @(negedge clk);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule